// File: doc/BRIEF.md
# Descriptor-chain DMA channel sequencer

This block is the control engine of one DMA channel. Software lays out a linked list of fixed-size descriptors in memory, points the channel at the first one and rings a doorbell. The sequencer then reads each descriptor over a simple memory master port and checks its valid flag. It passes the source address, destination address and byte count to a separate transfer datapath, and waits for that datapath to report completion. Each descriptor carries its own completion behaviour. A two-bit field selects what is written back, one bit selects where it is written, one bit asks for the valid flag to be cleared in memory, and one bit gates the interrupt output. After that the sequencer follows the descriptor's next pointer.

The chain ends at the first descriptor whose valid flag is clear. The channel halts with its pointer left on that descriptor. A later doorbell refetches the same address, so software can append work by validating that descriptor and ringing again. The data movement itself sits behind a start/done handshake.

The state machine has eight states. S_IDLE is the state after reset. S_FETCH reads the eight descriptor words. S_CHECK tests the valid flag. S_XFER runs the datapath handshake. S_WBACK performs the status write-back. S_CLRV clears the valid flag. S_NEXT loads the next pointer and signals completion. S_HALT is entered on an invalid descriptor.

The transitions are:
- S_IDLE or S_HALT to S_FETCH when the channel is enabled and a doorbell is pending.
- S_FETCH to S_CHECK after the eighth word is acknowledged.
- S_CHECK to S_XFER when the descriptor is valid, and to S_HALT when it is not.
- S_XFER to S_WBACK on transfer done.
- S_WBACK to S_CLRV, immediately for write-back mode 0 and otherwise on the write acknowledge.
- S_CLRV to S_NEXT, immediately when clear-valid is off and otherwise on the write acknowledge.
- S_NEXT to S_FETCH.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the status register (select 5) reads 0x1 (halted), the interrupt register (select 4) reads 0, the irq output is low and no memory request is made.
- R2: Register selects are 0 config, 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 interrupt, 5 status and 6 remaining count. While config bit 0 (enable) is clear, a doorbell write causes no memory access and the status register reads 0x5. Setting enable then starts the channel.
- R3: A fetch reads eight words in ascending order, at the pointer plus 0 through 28. Word 0 is cmd0, word 1 cmd1, word 2 source, word 4 destination, word 6 status and word 7 next pointer. Each request is word-aligned and is held with a stable address until it is acknowledged.
- R4: A descriptor with cmd0 bit 31 clear starts no transfer. The channel halts and the status register then reads 0x1.
- R5: A doorbell while the channel is halted refetches the descriptor at the current pointer.
- R6: For a valid descriptor, xfer_src is word 2, xfer_dst is word 4 and xfer_len is cmd1 bits 21:0. xfer_start is held until xfer_done, and no memory request is made during the transfer.
- R7: cmd0 bits 1:0 select the write-back. Mode 0 writes nothing. Mode 1 writes the current status register value, which is 0x2 during write-back. Mode 2 writes cmd0 with bit 31 cleared. Mode 3 writes the remaining byte count returned on xfer_remain.
- R8: cmd0 bit 4 clear sends the write-back to word 6 of the descriptor. Bit 4 set sends it to the address held in the status pointer register.
- R9: When cmd0 bit 2 is set, word 0 of the finished descriptor is rewritten with bit 31 cleared. When bit 2 is clear, word 0 is left unchanged.
- R10: Interrupt register bit 0 is set on every completed descriptor. The irq output is high only if a completed descriptor had cmd0 bit 8 set. Writing 1 to interrupt register bit 0 clears both.
- R11: After completion the descriptor pointer register reads word 7 bits 26:0 shifted left by 5, and the next fetch starts there.
- R12: The remaining-count register (select 6) reads the xfer_remain value of the last completed transfer.
- R13: Status register bit 0 is halted, bit 1 is the valid flag of the last fetched descriptor and bit 2 is doorbell pending. Doorbell pending is cleared when a fetch starts from idle or halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| xfer_start | output | 1 | Transfer request, held until done |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_len | output | 22 | Byte count |
| xfer_done | input | 1 | Transfer complete pulse |
| xfer_remain | input | 22 | Remaining byte count, valid with done |
| irq | output | 1 | Interrupt output |

## Verification
The bench sweeps all sixteen combinations of write-back mode, target select and clear-valid, one descriptor per run. Each run leaves the chain halted on the next, still invalid, slot, so every run also exercises the halt and refetch path.

The bench looks for these faults:
- A design that mixed up the write-back modes or targets would corrupt the wrong status word, or leave the right one stale.
- One that ignored clear-valid would leave bit 31 set in memory.
- One that failed to mask cmd1 to 22 bits, or word 7 to 27 bits, would show a wrong length or a wrong pointer, because the bench puts junk in the upper bits of both.
- One that gated the interrupt register with the enable bit would miss completions.
- One that ignored the config enable would fetch before being enabled.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 8;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ALIGN_W    = $clog2(DESC_WORDS * 4);
    localparam int NXT_W      = WORD_W - ALIGN_W;

    localparam int B_VALID = 31;
    localparam int B_IE    = 8;
    localparam int B_SPSEL = 4;
    localparam int B_CLRV  = 2;

    localparam logic [2:0] SEL_CFG   = 3'd0;
    localparam logic [2:0] SEL_DPTR  = 3'd1;
    localparam logic [2:0] SEL_SPTR  = 3'd2;
    localparam logic [2:0] SEL_BELL  = 3'd3;
    localparam logic [2:0] SEL_IRQ   = 3'd4;
    localparam logic [2:0] SEL_STAT  = 3'd5;
    localparam logic [2:0] SEL_REMN  = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_XFER, S_WBACK, S_CLRV, S_NEXT, S_HALT
    } seq_state_t;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              halted,
    input  logic              desc_valid,
    input  logic              db_clr,
    input  logic              load_ptr,
    input  logic [WORD_W-1:0] next_ptr,
    input  logic              done_pulse,
    input  logic              done_ie,
    input  logic [LEN_W-1:0]  remain,
    output logic              enable,
    output logic              db_pend,
    output logic [WORD_W-1:0] desc_ptr,
    output logic [WORD_W-1:0] stat_ptr,
    output logic [WORD_W-1:0] status_word,
    output logic              irq
);
    logic irq_pend, irq_ie;

    assign status_word = {{(WORD_W-3){1'b0}}, db_pend, desc_valid, halted};
    assign irq         = irq_pend & irq_ie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            db_pend  <= 1'b0;
            desc_ptr <= '0;
            stat_ptr <= '0;
            irq_pend <= 1'b0;
            irq_ie   <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_CFG)  enable   <= reg_wdata[0];
            if (reg_wr && reg_sel == SEL_SPTR) stat_ptr <= {reg_wdata[WORD_W-1:2], 2'b00};
            if (load_ptr)
                desc_ptr <= next_ptr;
            else if (reg_wr && reg_sel == SEL_DPTR)
                desc_ptr <= {reg_wdata[WORD_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
            if (reg_wr && reg_sel == SEL_BELL) db_pend <= 1'b1;
            else if (db_clr)                   db_pend <= 1'b0;
            if (done_pulse) begin
                irq_pend <= 1'b1;
                irq_ie   <= irq_ie | done_ie;
            end else if (reg_wr && reg_sel == SEL_IRQ && reg_wdata[0]) begin
                irq_pend <= 1'b0;
                irq_ie   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CFG:  reg_rdata = {{(WORD_W-1){1'b0}}, enable};
            SEL_DPTR: reg_rdata = desc_ptr;
            SEL_SPTR: reg_rdata = stat_ptr;
            SEL_IRQ:  reg_rdata = {{(WORD_W-1){1'b0}}, irq_pend};
            SEL_STAT: reg_rdata = status_word;
            SEL_REMN: reg_rdata = {{(WORD_W-LEN_W){1'b0}}, remain};
            default:  reg_rdata = '0;
        endcase
    end

    // R10
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_pulse));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              db_pend,
    input  logic [WORD_W-1:0] desc_ptr,
    input  logic [WORD_W-1:0] stat_ptr,
    input  logic [WORD_W-1:0] status_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_remain,
    output logic              db_clr,
    output logic              load_ptr,
    output logic [WORD_W-1:0] next_ptr,
    output logic              done_pulse,
    output logic              done_ie,
    output logic [LEN_W-1:0]  remain_q,
    output logic              desc_valid,
    output logic              halted
);
    seq_state_t state, nxt;
    logic [WORD_W-1:0] dw [DESC_WORDS];
    logic [IDX_W-1:0]  idx;
    logic [1:0]        wb_mode;
    logic [WORD_W-1:0] cmd0_cleared;

    assign wb_mode      = dw[0][1:0];
    assign cmd0_cleared = dw[0] & ~(WORD_W'(1) << B_VALID);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_HALT: if (enable && db_pend) nxt = S_FETCH;
            S_FETCH: if (mem_ack && idx == IDX_W'(DESC_WORDS-1)) nxt = S_CHECK;
            S_CHECK: nxt = dw[0][B_VALID] ? S_XFER : S_HALT;
            S_XFER:  if (xfer_done) nxt = S_WBACK;
            S_WBACK: if (wb_mode == 2'd0 || mem_ack) nxt = S_CLRV;
            S_CLRV:  if (!dw[0][B_CLRV] || mem_ack) nxt = S_NEXT;
            S_NEXT:  nxt = S_FETCH;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx        <= '0;
            desc_valid <= 1'b0;
            remain_q   <= '0;
            for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
        end else begin
            if (state == S_FETCH && mem_ack) begin
                dw[idx] <= mem_rdata;
                idx     <= idx + 1'b1;
            end
            if (state != S_FETCH) idx <= '0;
            if (state == S_CHECK) desc_valid <= dw[0][B_VALID];
            if (state == S_XFER && xfer_done) remain_q <= xfer_remain;
        end
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = desc_ptr + WORD_W'({idx, 2'b00});
        mem_wdata  = '0;
        xfer_start = (state == S_XFER);
        xfer_src   = dw[2];
        xfer_dst   = dw[4];
        xfer_len   = dw[1][LEN_W-1:0];
        db_clr     = (state == S_IDLE || state == S_HALT) && enable && db_pend;
        load_ptr   = (state == S_NEXT);
        next_ptr   = {dw[DESC_WORDS-1][NXT_W-1:0], {ALIGN_W{1'b0}}};
        done_pulse = (state == S_NEXT);
        done_ie    = dw[0][B_IE];
        halted     = (state == S_IDLE || state == S_HALT);
        unique case (state)
            S_FETCH: mem_req = 1'b1;
            S_WBACK: begin
                mem_req  = (wb_mode != 2'd0);
                mem_we   = 1'b1;
                mem_addr = dw[0][B_SPSEL] ? stat_ptr : desc_ptr + WORD_W'(24);
                unique case (wb_mode)
                    2'd1:    mem_wdata = status_word;
                    2'd2:    mem_wdata = cmd0_cleared;
                    2'd3:    mem_wdata = {{(WORD_W-LEN_W){1'b0}}, remain_q};
                    default: mem_wdata = '0;
                endcase
            end
            S_CLRV: begin
                mem_req   = dw[0][B_CLRV];
                mem_we    = 1'b1;
                mem_addr  = desc_ptr;
                mem_wdata = cmd0_cleared;
            end
            default: ;
        endcase
    end

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R3
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    // R6
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start && !xfer_done |=> xfer_start);
    // R6
    xfer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !mem_req);
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_start,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_remain,
    output logic              irq
);
    logic              enable, db_pend, db_clr, load_ptr, done_pulse, done_ie;
    logic              desc_valid, halted;
    logic [WORD_W-1:0] desc_ptr, stat_ptr, status_word, next_ptr;
    logic [LEN_W-1:0]  remain_q;

    dma_seq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .halted(halted),
        .desc_valid(desc_valid), .db_clr(db_clr), .load_ptr(load_ptr),
        .next_ptr(next_ptr), .done_pulse(done_pulse), .done_ie(done_ie),
        .remain(remain_q), .enable(enable), .db_pend(db_pend),
        .desc_ptr(desc_ptr), .stat_ptr(stat_ptr), .status_word(status_word),
        .irq(irq)
    );

    dma_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .db_pend(db_pend),
        .desc_ptr(desc_ptr), .stat_ptr(stat_ptr), .status_word(status_word),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_remain(xfer_remain),
        .db_clr(db_clr), .load_ptr(load_ptr), .next_ptr(next_ptr),
        .done_pulse(done_pulse), .done_ie(done_ie), .remain_q(remain_q),
        .desc_valid(desc_valid), .halted(halted)
    );
endmodule

// File: tb/dma_desc_seq_tb.sv
module dma_desc_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_start, xfer_done;
    logic [31:0] xfer_src, xfer_dst;
    logic [21:0] xfer_len, xfer_remain;
    logic        irq;

    logic [31:0] mem [256];
    logic        hw_we = 1'b0;
    logic [7:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    int          nreads, nxfers, any_req;
    logic [31:0] log_src, log_dst;
    logic [21:0] log_len;
    logic [1:0]  xcnt;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_desc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_start(xfer_start),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .xfer_remain(xfer_remain), .irq(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            nreads <= 0;
            any_req <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req) any_req <= any_req + 1;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        nreads <= nreads + 1;
            end
        end
        if (hw_we) mem[hw_idx] <= hw_data;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            xfer_remain <= '0;
            xcnt <= '0;
            nxfers <= 0;
        end else begin
            xfer_done <= 1'b0;
            if (xfer_start && !xfer_done) begin
                if (xcnt == 2'd2) begin
                    xfer_done <= 1'b1;
                    xfer_remain <= xfer_len >> 1;
                    xcnt <= '0;
                    log_src <= xfer_src;
                    log_dst <= xfer_dst;
                    log_len <= xfer_len;
                    nxfers <= nxfers + 1;
                end else xcnt <= xcnt + 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic mput(input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_idx = idx[7:0]; hw_data = d; hw_we = 1'b1;
        @(negedge clk);
        hw_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, cmd0, cmd1, wv;
        int r0;
        for (int k = 0; k < 256; k++) mem[k] = 32'h0;
        for (int k = 0; k < 16; k++) mem[192+k] = 32'hE000_0000 | k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rreg(3'd5, v); chk("R1 status after reset", v, 32'h1);
        rreg(3'd4, v); chk("R1 irq reg after reset", v, 32'h0);
        chk("R1 irq pin after reset", {31'd0, irq}, 32'h0);
        chk("R1 no mem request", {31'd0, mem_req}, 32'h0);

        for (int i = 0; i < 16; i++) begin
            logic [1:0] mode;
            logic sp, cv, ie;
            int b;
            mode = i[1:0]; sp = i[2]; cv = i[3]; ie = i[0] ^ i[3];
            b = 8 * i;
            cmd0 = 32'h8000_0000 | (32'(ie) << 8) | (32'(sp) << 4) | (32'(cv) << 2) | 32'(mode);
            cmd1 = 32'hA0C0_0000 | (100 + 7 * i);
            mput(b + 0, cmd0);
            mput(b + 1, cmd1);
            mput(b + 2, 32'h1000_0000 + 32'(i) * 32'h40);
            mput(b + 4, 32'h2000_0000 + 32'(i));
            mput(b + 6, 32'hD000_0000 | i);
            mput(b + 7, 32'hF800_0000 | (i + 1));
            wreg(3'd2, 32'h300 + 4 * i);
            wreg(3'd4, 32'h1);
            rreg(3'd4, v); chk("R10 irq reg cleared", v, 32'h0);
            chk("R10 irq pin cleared", {31'd0, irq}, 32'h0);
            r0 = nreads;
            if (i == 0) begin
                wreg(3'd1, 32'h0);
                wreg(3'd3, 32'h1234);
                repeat (20) @(negedge clk);
                chk("R2 no access while disabled", any_req, 0);
                rreg(3'd5, v); chk("R2 R13 status disabled with doorbell", v, 32'h5);
                wreg(3'd0, 32'h1);
            end else begin
                wreg(3'd3, 32'h0);
            end
            repeat (120) @(negedge clk);
            wv = (mode == 2'd1) ? 32'h2 : (mode == 2'd2) ? (cmd0 & 32'h7FFF_FFFF) : 32'((100 + 7 * i) >> 1);
            chk("R6 transfer count", nxfers, i + 1);
            chk("R6 source", log_src, 32'h1000_0000 + 32'(i) * 32'h40);
            chk("R6 destination", log_dst, 32'h2000_0000 + 32'(i));
            chk("R6 length masked", {10'd0, log_len}, 100 + 7 * i);
            chk("R3 R5 reads per run", nreads - r0, 16);
            chk("R7 R8 descriptor status word", mem[b + 6],
                (mode != 0 && !sp) ? wv : (32'hD000_0000 | i));
            chk("R7 R8 status pointer word", mem[192 + i],
                (mode != 0 && sp) ? wv : (32'hE000_0000 | i));
            chk("R9 cmd0 in memory", mem[b], cv ? (cmd0 & 32'h7FFF_FFFF) : cmd0);
            rreg(3'd4, v); chk("R10 irq reg set", v, 32'h1);
            chk("R10 irq pin follows IE", {31'd0, irq}, {31'd0, ie});
            rreg(3'd1, v); chk("R11 next pointer", v, 32 * (i + 1));
            rreg(3'd6, v); chk("R12 remaining count", v, (100 + 7 * i) >> 1);
            rreg(3'd5, v); chk("R4 R13 halted on invalid", v, 32'h1);
        end

        r0 = nreads;
        wreg(3'd3, 32'h0);
        repeat (60) @(negedge clk);
        chk("R5 refetch reads", nreads - r0, 8);
        chk("R4 no transfer on invalid", nxfers, 16);
        rreg(3'd5, v); chk("R4 still halted", v, 32'h1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule